// File: doc/BRIEF.md
# Flash erase command sequencer

This block stands in for the command side of a parallel NOR flash. It watches host write cycles, made of a word address, a data word and a one-cycle write strobe, and matches them against the unlock-and-erase command sequences. A full chip erase starts at once. A sector erase opens an acceptance window. While the window is open, more sector-erase writes can queue further sectors, and each one restarts the window. When the window expires, an internal flow walks the modelled array three times: it preprograms the selected words to zero, checks them, and then erases them to all ones.

During the window and the flow, a read returns a status word instead of array data. The host polls that word to learn whether the window has closed and whether the erase is still running. When the flow ends, reads return array contents again. No host timing or control is needed while the flow runs.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset, every array word i (i = 0 to SECTORS*SECT_WORDS-1) holds the byte (i[7:0] XOR 0x5A) repeated in every byte lane. In read mode, bus_rdata shows the word selected by the low address bits, with sector = bus_addr[5:2] and word-in-sector = bus_addr[1:0] by default.
- R2: The writes 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA, 0x10@0x555 start a chip erase. The flow status shows from the next cycle, and every word afterwards reads 0xFFFFFFFF. Only data bits [7:0] are decoded.
- R3: If the sixth write instead carries 0x30 at any address, the sector given by that address is queued. After the flow, only the queued sectors read all ones, and every other word is unchanged.
- R4: While the window is open, each further write of 0x30 adds the sector at its address to the queue and restarts the window timer.
- R5: Any other write while the window is open drops the queue and returns to read mode in the next cycle. Nothing is erased.
- R6: A write whose address or data does not match at any of the six sequence positions returns the decoder to read mode, and no erase follows.
- R7: Writes made while the flow is running are ignored. They neither alter the sectors erased nor queue new ones.
- R8: While the window is open, the status word is zero apart from bit 6. While the flow runs, bits 3, 11, 19 and 27 read 1, bit 7 reads 0, and the other bits apart from bit 6 read 0.
- R9: While the window or the flow is active, bit 6 of the status word inverts after each read strobe.
- R10: The flow begins exactly TIMEOUT_CYC clock cycles after the last accepted sector-erase write.
- R11: The flow runs a preprogram pass, a verify pass and an erase pass, each taking PHASE_CYC cycles per array word. Read mode returns exactly 3*WORDS*PHASE_CYC cycles after the flow starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe, one cycle per bus write |
| bus_re | input | 1 | Read strobe, one cycle per bus read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data; bits [7:0] are decoded |
| bus_rdata | output | DATA_W | Array word in read mode, status word otherwise |

## Verification
A decoder stuck in a partial-unlock state does not show up at once. It surfaces one write later, when an erase starts that should not have started or a valid one is refused. After that, the status word appears in place of array data within the next cycle. A wrong queue mask, or a write that leaks into the flow, stays hidden until the flow completes. Only then does a full sweep of the array expose words that were wrongly erased or wrongly kept. Timer and phase-length faults show up as a status change one cycle early or late, so the sweep samples both sides of each boundary.

// File: rtl/flash_erase_seq.sv
module flash_erase_seq #(
  parameter int SECTORS     = 16,
  parameter int SECT_WORDS  = 4,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 12,
  parameter int TIMEOUT_CYC = 6_250_000,
  parameter int PHASE_CYC   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam int WORDS = SECTORS * SECT_WORDS;
  localparam int OFF_W = $clog2(SECT_WORDS);
  localparam int IDX_W = $clog2(WORDS);
  localparam int TMR_W = $clog2(TIMEOUT_CYC + 1);
  localparam int PH_W  = $clog2(PHASE_CYC + 1);
  localparam int LANES = DATA_W / 8;
  localparam logic [ADDR_W-1:0] KEY_A = ADDR_W'(12'h555);
  localparam logic [ADDR_W-1:0] KEY_B = ADDR_W'(12'h2AA);

  typedef enum logic [3:0] {
    S_READ, S_C1, S_C2, S_C3, S_C4, S_C5, S_WIN, S_PRE, S_VER, S_ERS
  } st_t;

  st_t                st;
  logic [SECTORS-1:0] mask;
  logic [TMR_W-1:0]   tmr;
  logic [IDX_W-1:0]   idx;
  logic [PH_W-1:0]    cnt;
  logic               tgl;
  logic [DATA_W-1:0]  mem [WORDS];
  logic [DATA_W-1:0]  stat;

  function automatic logic [DATA_W-1:0] seed(int i);
    return {LANES{8'(i) ^ 8'h5A}};
  endfunction

  wire [7:0] wd      = bus_wdata[7:0];
  wire       at_a    = bus_addr == KEY_A;
  wire       at_b    = bus_addr == KEY_B;
  wire [SECTORS-1:0] sec_bit = SECTORS'(1) << bus_addr[IDX_W-1:OFF_W];
  wire       flow    = st == S_PRE || st == S_VER || st == S_ERS;
  wire       busy    = flow || st == S_WIN;
  wire       step    = cnt == PH_W'(PHASE_CYC - 1);
  wire       last    = step && idx == IDX_W'(WORDS - 1);
  wire       sel     = mask[idx[IDX_W-1:OFF_W]];

  always_comb begin
    stat = '0;
    for (int l = 0; l < LANES; l++) stat[8*l+3] = flow;
    stat[6] = tgl;
  end

  assign bus_rdata = busy ? stat : mem[bus_addr[IDX_W-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_READ; mask <= '0; tmr <= '0; idx <= '0; cnt <= '0; tgl <= 1'b0;
    end else begin
      if (busy && bus_re) tgl <= ~tgl;
      case (st)
        S_READ: if (bus_we) st <= (at_a && wd == 8'hAA) ? S_C1 : S_READ;
        S_C1:   if (bus_we) st <= (at_b && wd == 8'h55) ? S_C2 : S_READ;
        S_C2:   if (bus_we) st <= (at_a && wd == 8'h80) ? S_C3 : S_READ;
        S_C3:   if (bus_we) st <= (at_a && wd == 8'hAA) ? S_C4 : S_READ;
        S_C4:   if (bus_we) st <= (at_b && wd == 8'h55) ? S_C5 : S_READ;
        S_C5:
          if (bus_we) begin
            if (at_a && wd == 8'h10) begin
              mask <= '1; idx <= '0; cnt <= '0; st <= S_PRE;
            end else if (wd == 8'h30) begin
              mask <= sec_bit; tmr <= '0; st <= S_WIN;
            end else st <= S_READ;
          end
        S_WIN:
          if (bus_we) begin
            if (wd == 8'h30) begin
              mask <= mask | sec_bit; tmr <= '0;
            end else begin
              mask <= '0; st <= S_READ;
            end
          end else if (tmr == TMR_W'(TIMEOUT_CYC - 1)) begin
            idx <= '0; cnt <= '0; st <= S_PRE;
          end else tmr <= tmr + 1'b1;
        S_PRE, S_VER, S_ERS:
          if (step) begin
            cnt <= '0;
            if (last) begin
              idx <= '0;
              if (st == S_PRE) st <= S_VER;
              else if (st == S_VER) st <= S_ERS;
              else begin
                st <= S_READ; mask <= '0;
              end
            end else idx <= idx + 1'b1;
          end else cnt <= cnt + 1'b1;
        default: st <= S_READ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= seed(i);
    end else if (step && sel) begin
      if (st == S_PRE) mem[idx] <= '0;
      else if (st == S_ERS) mem[idx] <= '1;
    end
  end

  // R5
  mask_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> mask == '0);

  // R4
  win_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_WIN |-> mask != '0);

  // R10
  timer_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_WIN |-> tmr < TMR_W'(TIMEOUT_CYC));

  // R7
  flow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flow && !(st == S_ERS && last)) |=> ($stable(mask) && flow));

  // R11
  verify_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_VER && sel) |-> mem[idx] == '0);

  // R9
  toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_re) |=> tgl != $past(tgl));

  // R8
  status_b7_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> bus_rdata[7] == 1'b0);
endmodule

// File: tb/flash_erase_seq_tb.sv
module flash_erase_seq_tb;
  localparam int T    = 20;
  localparam int P    = 2;
  localparam int N    = 64;
  localparam int FLOW = 3 * N * P;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] exp_mem [N];
  logic [31:0] d, d2;

  always #4 clk = ~clk;

  flash_erase_seq #(.TIMEOUT_CYC(T), .PHASE_CYC(P)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] v);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = v;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic unlock5();
    wr(12'h555, 32'hAA); wr(12'h2AA, 32'h55); wr(12'h555, 32'h80);
    wr(12'h555, 32'hAA); wr(12'h2AA, 32'h55);
  endtask

  task automatic peek(input logic [11:0] a, output logic [31:0] v);
    bus_addr = a; #1; v = bus_rdata;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    @(negedge clk); bus_addr = a; bus_re = 1'b1; #1; v = bus_rdata;
    @(negedge clk); bus_re = 1'b0;
  endtask

  task automatic sweep(input string tag);
    logic [31:0] v;
    for (int i = 0; i < N; i++) begin
      peek(12'(i), v);
      check(v === exp_mem[i], tag, v, exp_mem[i]);
    end
  endtask

  task automatic model_erase(input int s);
    for (int w = 0; w < 4; w++) exp_mem[s*4+w] = 32'hFFFF_FFFF;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    summary();
    $finish;
  end

  initial begin
    logic [11:0] ca [6];
    logic [7:0]  cd [6];
    ca = '{12'h555, 12'h2AA, 12'h555, 12'h555, 12'h2AA, 12'h555};
    cd = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55, 8'h10};
    for (int i = 0; i < N; i++) exp_mem[i] = {4{8'(i) ^ 8'h5A}};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    sweep("R1 reset contents");

    // R6: mismatch at every position, alternating bad address and bad data
    for (int p = 0; p < 6; p++) begin
      for (int c = 0; c < p; c++) wr(ca[c], {24'h0, cd[c]});
      if (p % 2 == 0) wr(ca[p] ^ 12'h001, {24'h0, cd[p]});
      else wr(ca[p], {24'h0, cd[p] ^ 8'hFF});
      peek(12'(p), d);
      check(d === exp_mem[p], "R6 read mode after mismatch", d, exp_mem[p]);
    end
    repeat (T + FLOW + 10) @(negedge clk);
    sweep("R6 nothing erased");

    // R3 R10 R8 R11: single sector, exact timing
    unlock5(); wr(12'd12, 32'h30);
    repeat (T - 1) @(negedge clk);
    peek(12'h0, d);
    check((d & ~32'h40) === 32'h0, "R10 R8 window still open", d, 32'h0);
    @(negedge clk);
    peek(12'h0, d);
    check((d & ~32'h40) === 32'h0808_0808, "R10 R8 flow started", d, 32'h0808_0808);
    repeat (FLOW - 1) @(negedge clk);
    peek(12'h0, d);
    check((d & ~32'h40) === 32'h0808_0808, "R11 still busy at last cycle", d, 32'h0808_0808);
    @(negedge clk);
    peek(12'h0, d);
    check(d === exp_mem[0], "R11 read mode after flow", d, exp_mem[0]);
    model_erase(3);
    sweep("R3 single sector erased");

    // R4 R9 R7: three sectors, timer restarts, writes during flow
    unlock5(); wr(12'd36, 32'h30);
    repeat (10) @(negedge clk);
    wr(12'd0, 32'h30);
    repeat (15) @(negedge clk);
    wr(12'd61, 32'h30);
    repeat (T - 1) @(negedge clk);
    peek(12'h0, d);
    check((d & ~32'h40) === 32'h0, "R4 timer restarted", d, 32'h0);
    @(negedge clk);
    peek(12'h0, d);
    check((d & ~32'h40) === 32'h0808_0808, "R4 flow after restart", d, 32'h0808_0808);
    rd(12'h0, d); rd(12'h0, d2);
    check(d[6] !== d2[6], "R9 toggle in flow", d2, d ^ 32'h40);
    unlock5(); wr(12'h555, 32'h10); wr(12'd20, 32'h30); wr(12'd7, 32'hF0);
    peek(12'h0, d);
    check((d & ~32'h40) === 32'h0808_0808, "R7 flow unaffected", d, 32'h0808_0808);
    repeat (FLOW) @(negedge clk);
    model_erase(9); model_erase(0); model_erase(15);
    sweep("R4 R7 queued sectors only");

    // R5 R9: abort inside window
    unlock5(); wr(12'd20, 32'h30);
    rd(12'h0, d); rd(12'h0, d2);
    check(d[6] !== d2[6], "R9 toggle in window", d2, d ^ 32'h40);
    wr(12'd7, 32'hF0);
    peek(12'd20, d);
    check(d === exp_mem[20], "R5 read mode right after abort", d, exp_mem[20]);
    repeat (T + FLOW + 10) @(negedge clk);
    sweep("R5 abort erased nothing");

    // R2: chip erase
    unlock5(); wr(12'h555, 32'h10);
    peek(12'h0, d);
    check((d & ~32'h40) === 32'h0808_0808, "R2 chip erase starts at once", d, 32'h0808_0808);
    repeat (FLOW) @(negedge clk);
    for (int s = 0; s < 16; s++) model_erase(s);
    sweep("R2 chip erased");

    summary();
    $finish;
  end
endmodule